// File: doc/BRIEF.md
# Serial Flash Boot SPI Master

This block is a register-mapped SPI master that a boot processor uses to read a serial flash. Software loads a 32-bit transmit word, picks how the chip select behaves, and then writes a control word. The control word holds three things: the number of SCK pulses, the number of leading bits to drive on MOSI, and a start bit. The block then runs the transfer on its own. While it runs, it samples MISO into a receive register. When it finishes, it sets a done flag, and software polls that flag.

The pulse count and the MOSI length are set separately. A command byte can therefore be followed by further clocks that only collect read data. A MOSI length of zero gives a read-only transfer. SCK is the system clock divided by a fixed even parameter (4 by default). The bus protocol is mode 0: SCK idles low, MISO is taken on the rising SCK edge, and MOSI moves on the falling edge.

Top module: `spim_flash_master`

## Requirements
- R1: The setup register (address 0, bits [1:0]) selects the chip select. Value 3 holds spi_cs_n high even during a transfer. Value 2 holds it low even when idle. Value 0 behaves as 3. The register resets to 3.
- R2: With setup value 1 (automatic), spi_cs_n goes low on the clock edge that starts a transfer. It stays low through the last SCK pulse and returns high when the transfer ends.
- R3: The control register is at address 2. Its fields are bits [15:8] = pulse count C, bit 7 = start and bits [6:0] = MOSI length L. A write with start set produces exactly C+1 SCK pulses, each CLK_DIV system cycles long. SCK is low whenever no transfer runs.
- R4: The transmit word (address 1) goes out on MOSI MSB first, beginning with bit 31. Each bit is valid at the rising SCK edge that samples it.
- R5: After L bits, MOSI is 0 for the remaining pulses. L = 0 gives an all-zero MOSI read-only transfer. MOSI is 0 while idle.
- R6: Status (address 3) has bit 0 = done and bit 1 = busy. An accepted start clears done and sets busy. Done sets, and busy clears, after the last pulse.
- R7: The receive register (address 4) is cleared at each start. MISO is shifted in at bit 0 on every rising SCK edge, so the last bit received sits in bit 0. Its value does not change while idle.
- R8: A start written while a transfer is busy is ignored. The running transfer keeps its pulse count.
- R9: A bus write to the receive register address leaves its contents unchanged.
- R10: Read data appears on bus_rdata one cycle after bus_rd. After reset, spi_cs_n is 1, status reads 0 and receive reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The transfers use different pulse counts and MOSI lengths:
- A 40-pulse transfer with a full 32-bit command shows that only the last 32 received bits are kept.
- A 16-pulse transfer with an 8-bit command separates the command bits from the zero fill, and shows the reply byte landing in the low byte.
- A 32-pulse transfer with length zero confirms the read-only case.
- A single-pulse transfer tests the smallest count.

A flash model in the bench shifts out a known 64-bit reply and records every MOSI bit and the chip-select level at each rising edge. This makes misordered, shifted or miscounted data visible.

Further runs cover the remaining cases:
- Forced-high and forced-low chip-select runs tell the three select modes apart.
- A second start injected mid-transfer checks that busy starts are dropped.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    SEL_SETUP = 3'd0,
    SEL_TX    = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_RX    = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    CSM_OFF  = 2'd0,
    CSM_AUTO = 2'd1,
    CSM_LOW  = 2'd2,
    CSM_HIGH = 2'd3
  } cs_mode_e;

  localparam int CNT_W    = 8;
  localparam int LEN_W    = 7;
  localparam int CNT_LSB  = 8;
  localparam int START_BIT = 7;
endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_word,
  output cs_mode_e          cs_mode,
  output logic [DATA_W-1:0] tx_word,
  output logic              start_req,
  output logic [CNT_W-1:0]  req_cnt,
  output logic [LEN_W-1:0]  req_len
);
  logic [DATA_W-1:0] setup_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] stat_word;

  assign cs_mode   = cs_mode_e'(setup_q[1:0]);
  assign tx_word   = tx_q;
  assign stat_word = {{(DATA_W-2){1'b0}}, busy, done};

  // start request and its fields come straight from the bus write
  assign start_req = bus_wr && (bus_addr == ADDR_W'(SEL_CTRL)) && bus_wdata[START_BIT];
  assign req_cnt   = bus_wdata[CNT_LSB +: CNT_W];
  assign req_len   = bus_wdata[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q <= DATA_W'(CSM_HIGH);
      ctrl_q  <= '0;
      tx_q    <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_W'(SEL_SETUP): setup_q <= bus_wdata;
        ADDR_W'(SEL_TX):    tx_q    <= bus_wdata;
        ADDR_W'(SEL_CTRL):  ctrl_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(SEL_SETUP): bus_rdata <= setup_q;
        ADDR_W'(SEL_TX):    bus_rdata <= tx_q;
        ADDR_W'(SEL_CTRL):  bus_rdata <= ctrl_q;
        ADDR_W'(SEL_STAT):  bus_rdata <= stat_word;
        ADDR_W'(SEL_RX):    bus_rdata <= rx_word;
        default:            bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [CNT_W-1:0]  req_cnt,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              launch,
  output logic              finish,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DIV_W-1:0]  div_cnt;
  logic [CNT_W-1:0]  pulses_left;
  logic [LEN_W-1:0]  bits_left;
  logic [DATA_W-1:0] tx_sh;
  logic              tick;

  assign tick   = (div_cnt == DIV_W'(HALF - 1));
  assign launch = start_req && !busy;
  assign finish = busy && tick && sck && (pulses_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      sck         <= 1'b0;
      mosi        <= 1'b0;
      div_cnt     <= '0;
      pulses_left <= '0;
      bits_left   <= '0;
      tx_sh       <= '0;
      rx_word     <= '0;
    end else if (launch) begin
      busy        <= 1'b1;
      done        <= 1'b0;
      sck         <= 1'b0;
      div_cnt     <= '0;
      pulses_left <= req_cnt;
      rx_word     <= '0;
      mosi        <= (req_len != '0) && tx_word[DATA_W-1];
      bits_left   <= (req_len != '0) ? req_len - 1'b1 : '0;
      tx_sh       <= {tx_word[DATA_W-2:0], 1'b0};
    end else if (busy) begin
      if (tick) begin
        div_cnt <= '0;
        if (!sck) begin
          sck     <= 1'b1;
          rx_word <= {rx_word[DATA_W-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (pulses_left == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
            mosi <= 1'b0;
          end else begin
            pulses_left <= pulses_left - 1'b1;
            mosi        <= (bits_left != '0) && tx_sh[DATA_W-1];
            tx_sh       <= {tx_sh[DATA_W-2:0], 1'b0};
            if (bits_left != '0) bits_left <= bits_left - 1'b1;
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spim_cs.sv
module spim_cs
  import spim_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  cs_mode_e cs_mode,
  input  logic     launch,
  input  logic     finish,
  input  logic     busy,
  output logic     cs_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n <= 1'b1;
    end else begin
      case (cs_mode)
        CSM_LOW:  cs_n <= 1'b0;
        CSM_AUTO: cs_n <= !(launch || (busy && !finish));
        default:  cs_n <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/spim_flash_master.sv
module spim_flash_master
  import spim_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  cs_mode_e          cs_mode;
  logic [DATA_W-1:0] tx_word;
  logic [DATA_W-1:0] rx_word;
  logic              start_req;
  logic [CNT_W-1:0]  req_cnt;
  logic [LEN_W-1:0]  req_len;
  logic              busy;
  logic              done;
  logic              launch;
  logic              finish;

  spim_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .rx_word(rx_word), .cs_mode(cs_mode),
    .tx_word(tx_word), .start_req(start_req), .req_cnt(req_cnt),
    .req_len(req_len)
  );

  spim_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) engine_i (
    .clk(clk), .rst(rst), .start_req(start_req), .req_cnt(req_cnt),
    .req_len(req_len), .tx_word(tx_word), .miso(spi_miso), .busy(busy),
    .done(done), .launch(launch), .finish(finish), .sck(spi_sck),
    .mosi(spi_mosi), .rx_word(rx_word)
  );

  spim_cs cs_i (
    .clk(clk), .rst(rst), .cs_mode(cs_mode), .launch(launch),
    .finish(finish), .busy(busy), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/spim_flash_master_chk.sv
module spim_flash_master_chk
  import spim_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input cs_mode_e          cs_mode,
  input logic              busy,
  input logic              done,
  input logic              launch,
  input logic              finish,
  input logic [DATA_W-1:0] rx_word,
  input logic              spi_sck,
  input logic              spi_cs_n,
  input logic              spi_mosi
);
  // R1
  cs_forced_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_mode == CSM_HIGH) |=> spi_cs_n);

  // R1
  cs_forced_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_mode == CSM_LOW) |=> !spi_cs_n);

  // R2
  cs_auto_active_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_mode == CSM_AUTO && busy && !finish) |=> !spi_cs_n);

  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spi_sck);

  // R5
  mosi_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spi_mosi);

  // R6
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R6
  start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> (busy && !done));

  // R7
  rx_hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !launch) |=> $stable(rx_word));
endmodule

bind spim_flash_master spim_flash_master_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .cs_mode(cs_mode), .busy(busy), .done(done),
  .launch(launch), .finish(finish), .rx_word(rx_word), .spi_sck(spi_sck),
  .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/spim_flash_master_tb.sv
module spim_flash_master_tb_top;
  typedef struct {
    string       tag;
    logic [31:0] rx;
    int          pulses;
    int          mosi_err;
    int          cs_bad;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  item_t exp_q[$];
  item_t obs_q[$];

  logic [63:0] resp = '0;
  int          pcnt = 0;
  logic        mosi_bits [256];
  int          cs_bad = 0;
  logic        exp_cs = 1'b0;

  always #4 clk = ~clk;

  spim_flash_master dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // flash model: reply bit k is resp[63 - k mod 64]
  logic [5:0] ridx;
  assign ridx     = pcnt[5:0];
  assign spi_miso = resp[6'd63 - ridx];

  always @(posedge spi_sck) begin
    if (pcnt < 256) mosi_bits[pcnt] = spi_mosi;
    if (spi_cs_n !== exp_cs) cs_bad = cs_bad + 1;
    pcnt = pcnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // driver: pushes the expected item, runs the transfer, pushes what was seen
  task automatic run_xfer(input string tag, input logic [31:0] tx,
                          input logic [7:0] cnt, input logic [6:0] len,
                          input logic [63:0] r, input logic cs_lvl,
                          input bit inject);
    item_t e, o;
    logic [31:0] d;
    int n, err, tries;
    n = int'(cnt) + 1;
    e.tag = tag; e.pulses = n; e.mosi_err = 0; e.cs_bad = 0; e.rx = '0;
    for (int k = 0; k < n; k++) e.rx = {e.rx[30:0], r[63 - (k % 64)]};
    resp = r; pcnt = 0; cs_bad = 0; exp_cs = cs_lvl;
    bus_write(3'd1, tx);
    exp_q.push_back(e);
    bus_write(3'd2, {16'h0, cnt, 1'b1, len});
    if (inject) begin
      bus_read(3'd3, d);
      // R6: accepted start shows busy set and done cleared
      check(d[1:0] == 2'b10, "R6 status after start", d, 32'h2);
      bus_write(3'd2, 32'h0000_0381);  // R8: must be dropped
    end
    tries = 0;
    do begin
      bus_read(3'd3, d);
      tries++;
    end while (d[0] !== 1'b1 && tries < 3000);
    check(d[1:0] == 2'b01, "R6 done at end", d, 32'h1);
    bus_read(3'd4, d);
    err = 0;
    for (int k = 0; k < pcnt && k < 256; k++) begin
      logic eb;
      eb = (k < int'(len) && k < 32) ? tx[31 - k] : 1'b0;
      if (mosi_bits[k] !== eb) err++;
    end
    o.tag = tag; o.rx = d; o.pulses = pcnt; o.mosi_err = err; o.cs_bad = cs_bad;
    obs_q.push_back(o);
  endtask

  // monitor: pops and compares
  initial begin
    item_t e, o;
    forever begin
      wait (obs_q.size() > 0 && exp_q.size() > 0);
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      check(o.rx == e.rx, {e.tag, " R7 rx word"}, o.rx, e.rx);
      check(o.pulses == e.pulses, {e.tag, " R3 pulse count"}, o.pulses, e.pulses);
      check(o.mosi_err == 0, {e.tag, " R4/R5 mosi bit errors"}, o.mosi_err, 0);
      check(o.cs_bad == 0, {e.tag, " R1/R2 cs level at edges"}, o.cs_bad, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R10: reset state
    check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R10 reset pins", {30'h0, spi_cs_n, spi_sck}, 32'h2);
    bus_read(3'd3, d); check(d == 32'h0, "R10 reset status", d, 32'h0);
    bus_read(3'd4, d); check(d == 32'h0, "R10 reset rx", d, 32'h0);
    bus_read(3'd0, d); check(d == 32'h3, "R1 setup reset value", d, 32'h3);

    bus_write(3'd0, 32'h1);  // automatic select
    run_xfer("id40", 32'h9000_0000, 8'h27, 7'd32, 64'h12BF_5A3C_0F81_E7D4, 1'b0, 1'b0);
    check(spi_cs_n === 1'b1, "R2 cs high after transfer", {31'h0, spi_cs_n}, 32'h1);
    run_xfer("id16", 32'h9F00_0000, 8'h0F, 7'd8, 64'hFF20_0000_0000_0000, 1'b0, 1'b0);
    run_xfer("read32", 32'hFFFF_FFFF, 8'h1F, 7'd0, 64'hC0FF_EE42_1357_9BDF, 1'b0, 1'b0);
    run_xfer("one", 32'h8000_0000, 8'h00, 7'd1, 64'h8000_0000_0000_0000, 1'b0, 1'b0);
    run_xfer("busy", 32'hA5C3_0000, 8'h0F, 7'd16, 64'h6B29_0000_0000_0000, 1'b0, 1'b1);

    // R9: write to rx address is ignored
    bus_write(3'd4, 32'hDEAD_BEEF);
    bus_read(3'd4, d);
    check(d == 32'h0000_6B29, "R9 rx unchanged after write", d, 32'h6B29);

    // R1: forced low holds select while idle, forced high blocks it during transfer
    bus_write(3'd0, 32'h2);
    repeat (2) @(negedge clk);
    check(spi_cs_n === 1'b0, "R1 forced low idle", {31'h0, spi_cs_n}, 32'h0);
    run_xfer("flow", 32'h0300_0000, 8'h07, 7'd8, 64'h3C00_0000_0000_0000, 1'b0, 1'b0);
    bus_write(3'd0, 32'h3);
    run_xfer("fhigh", 32'h0500_0000, 8'h07, 7'd8, 64'h9600_0000_0000_0000, 1'b1, 1'b0);

    wait (obs_q.size() == 0);
    @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule